// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the add/subtract unit of a load/store processor datapath. Each cycle it takes two 32-bit operands, a 3-bit operation code and the current carry flag. From these it forms one of six sums: plain add, add with carry, subtract, subtract with borrow, reverse subtract and reverse subtract with borrow. The result and the candidate negative, zero, carry and overflow flags are produced combinationally, in the same cycle as the operands.

A five-bit status register sits behind the flag logic. It loads the four candidate flags only when the instruction asks for it through a set-flags input. It also keeps a sticky overflow bit that collects every flag-setting overflow. An explicit status write replaces all five bits, and that write is the only way to clear the sticky bit. Subtraction treats carry as "no borrow": every subtract is built as `x + ~y + cin`.

Top module: `int_alu_flags`

## Requirements
- R1: Code 0 (add) gives a+b and ignores `carry_i`; code 1 (add with carry) gives a+b+`carry_i`.
- R2: Code 2 (subtract) gives a−b; code 3 gives a−b−(1−`carry_i`).
- R3: Code 4 (reverse subtract) gives b−a; code 5 gives b−a−(1−`carry_i`). With a=0x0000000A and b=0x0A0B0C0D, code 4 gives 0x0A0B0C03.
- R4: `cand_flags_o[3]` (N) equals result bit 31, and `cand_flags_o[2]` (Z) is 1 exactly when the result is zero.
- R5: `cand_flags_o[1]` (C) is the adder carry out. For the subtract forms, 1 means no borrow occurred.
- R6: `cand_flags_o[0]` (V) is 1 exactly when the operation overflows as signed two's complement.
- R7: With `set_flags_i`=1 and `stat_we_i`=0, `status_o[4:1]` (N,Z,C,V) takes the candidate flags at the clock edge. With both low, `status_o` holds its value.
- R8: `status_o[0]` (Q) is set by a flag-setting operation whose V is 1. It then stays 1 until a status write.
- R9: With `stat_we_i`=1, `status_o` takes `stat_wdata_i` (bit 4 N, 3 Z, 2 C, 1 V, 0 Q) at the edge. This overrides `set_flags_i` and a pending Q set.
- R10: Reset (active low) clears `status_o` to 0.
- R11: `result_o` and `cand_flags_o` follow the inputs in the same cycle, without a clock edge.
- R12: Unused codes 6 and 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second operand (register or immediate) |
| carry_i | input | 1 | Incoming carry flag |
| set_flags_i | input | 1 | Load the candidate flags into status |
| stat_we_i | input | 1 | Explicit status write enable |
| stat_wdata_i | input | 5 | Status write value {N,Z,C,V,Q} |
| result_o | output | 32 | Arithmetic result |
| cand_flags_o | output | 4 | Candidate flags {N,Z,C,V} |
| status_o | output | 5 | Status register {N,Z,C,V,Q} |

## Verification
The hardest state to reach is a set sticky bit that must survive later flag-setting operations whose V is 0. It must then drop only on an explicit write, even when that write arrives in the same cycle as a fresh overflow. The stimulus reaches it in three steps. Signed-overflow vectors in the table set Q first. A no-overflow flag-setting operation follows, to show that Q persists. Last, a status write of zero arrives together with an overflowing add and set-flags, and a later non-overflow operation shows that Q stays clear.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBC = 3'd3,
      OP_RSB = 3'd4,
      OP_RSC = 3'd5
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   localparam int STAT_W = 5;
   localparam int ST_Q   = 0;

endpackage

// File: rtl/alu_operand_route.sv
module alu_operand_route
   import alu_flag_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] x_o,
   output logic [WIDTH-1:0] y_o,
   output logic             cin_o
);

   always_comb begin
      x_o   = a_i;
      y_o   = b_i;
      cin_o = 1'b0;
      unique case (op_i)
         OP_ADC: begin
            cin_o = carry_i;
         end
         OP_SUB: begin
            y_o   = ~b_i;
            cin_o = 1'b1;
         end
         OP_SBC: begin
            y_o   = ~b_i;
            cin_o = carry_i;
         end
         OP_RSB: begin
            x_o   = b_i;
            y_o   = ~a_i;
            cin_o = 1'b1;
         end
         OP_RSC: begin
            x_o   = b_i;
            y_o   = ~a_i;
            cin_o = carry_i;
         end
         default: begin
            x_o   = a_i;
            y_o   = b_i;
            cin_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH = 32,
   parameter int ARCH  = 0   // 0: inferred carry chain, 1: explicit ripple cells
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             cmsb_o
);

   localparam int LOW_W = WIDTH - 1;

   generate
      if (ARCH == 0) begin : g_infer
         logic [WIDTH:0] full;
         logic [LOW_W:0] low;
         assign full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
         assign low    = {1'b0, x_i[LOW_W-1:0]} + {1'b0, y_i[LOW_W-1:0]}
                       + {{LOW_W{1'b0}}, cin_i};
         assign sum_o  = full[WIDTH-1:0];
         assign cout_o = full[WIDTH];
         assign cmsb_o = low[LOW_W];
      end else begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]  = x_i[i] ^ y_i[i] ^ cy[i];
            assign cy[i+1]   = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
         end
         assign cout_o = cy[WIDTH];
         assign cmsb_o = cy[WIDTH-1];
      end
   endgenerate

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
   import alu_flag_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] sum_i,
   input  logic             cout_i,
   input  logic             cmsb_i,
   output nzcv_t            flags_o
);

   always_comb begin
      flags_o.n = sum_i[WIDTH-1];
      flags_o.z = (sum_i == '0);
      flags_o.c = cout_i;
      flags_o.v = cout_i ^ cmsb_i;
   end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
   import alu_flag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_flags_i,
   input  nzcv_t             cand_i,
   input  logic              we_i,
   input  logic [STAT_W-1:0] wdata_i,
   output logic [STAT_W-1:0] status_o
);

   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] stat_d;

   always_comb begin
      stat_d = stat_q;
      if (we_i) begin
         stat_d = wdata_i;
      end else if (set_flags_i) begin
         stat_d = {cand_i, stat_q[ST_Q] | cand_i.v};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign status_o = stat_q;

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
   import alu_flag_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ADDER_ARCH = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic [WIDTH-1:0]  a_i,
   input  logic [WIDTH-1:0]  b_i,
   input  logic              carry_i,
   input  logic              set_flags_i,
   input  logic              stat_we_i,
   input  logic [STAT_W-1:0] stat_wdata_i,
   output logic [WIDTH-1:0]  result_o,
   output logic [3:0]        cand_flags_o,
   output logic [STAT_W-1:0] status_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("int_alu_flags: WIDTH must be at least 2");
      end
      if (ADDER_ARCH != 0 && ADDER_ARCH != 1) begin : g_bad_arch
         $error("int_alu_flags: ADDER_ARCH must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] x_w;
   logic [WIDTH-1:0] y_w;
   logic             cin_w;
   logic [WIDTH-1:0] sum_w;
   logic             cout_w;
   logic             cmsb_w;
   nzcv_t            flags_w;

   alu_operand_route #(.WIDTH(WIDTH)) u_route (
      .op_i    (op_i),
      .a_i     (a_i),
      .b_i     (b_i),
      .carry_i (carry_i),
      .x_o     (x_w),
      .y_o     (y_w),
      .cin_o   (cin_w)
   );

   alu_adder #(.WIDTH(WIDTH), .ARCH(ADDER_ARCH)) u_adder (
      .x_i    (x_w),
      .y_i    (y_w),
      .cin_i  (cin_w),
      .sum_o  (sum_w),
      .cout_o (cout_w),
      .cmsb_o (cmsb_w)
   );

   alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
      .sum_i   (sum_w),
      .cout_i  (cout_w),
      .cmsb_i  (cmsb_w),
      .flags_o (flags_w)
   );

   alu_status_reg u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_flags_i (set_flags_i),
      .cand_i      (flags_w),
      .we_i        (stat_we_i),
      .wdata_i     (stat_wdata_i),
      .status_o    (status_o)
   );

   assign result_o     = sum_w;
   assign cand_flags_o = flags_w;

endmodule

// File: rtl/int_alu_flags_chk.sv
module int_alu_flags_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       op_i,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             set_flags_i,
   input logic             stat_we_i,
   input logic [4:0]       stat_wdata_i,
   input logic [WIDTH-1:0] result_o,
   input logic [3:0]       cand_flags_o,
   input logic [4:0]       status_o
);

   AST_HOLD_WITHOUT_S: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_flags_i && !stat_we_i) |=> $stable(status_o)); // R7

   AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags_i && !stat_we_i) |=> (status_o[4:1] == $past(cand_flags_o))); // R7

   AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[0] && !stat_we_i) |=> status_o[0]); // R8

   AST_Q_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags_i && !stat_we_i && cand_flags_o[0]) |=> status_o[0]); // R8

   AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we_i |=> (status_o == $past(stat_wdata_i))); // R9

   AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd0 && cand_flags_o[0]) |->
      (a_i[WIDTH-1] == b_i[WIDTH-1] && result_o[WIDTH-1] != a_i[WIDTH-1])); // R6

endmodule

bind int_alu_flags int_alu_flags_chk #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_i         (op_i),
   .a_i          (a_i),
   .b_i          (b_i),
   .set_flags_i  (set_flags_i),
   .stat_we_i    (stat_we_i),
   .stat_wdata_i (stat_wdata_i),
   .result_o     (result_o),
   .cand_flags_o (cand_flags_o),
   .status_o     (status_o)
);

// File: tb/int_alu_flags_tb.sv
module int_alu_flags_tb;

   localparam int W  = 32;
   localparam int NV = 17;
   // {op, carry, a, b, expected result, expected NZCV}
   localparam logic [103:0] VEC [NV] = '{
      {3'd0, 1'b1, 32'h00000001, 32'h00000002, 32'h00000003, 4'b0000},
      {3'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0110},
      {3'd0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b1001},
      {3'd1, 1'b1, 32'h00000005, 32'h00000006, 32'h0000000C, 4'b0000},
      {3'd1, 1'b0, 32'h00000005, 32'h00000006, 32'h0000000B, 4'b0000},
      {3'd2, 1'b0, 32'h0000000A, 32'h00000003, 32'h00000007, 4'b0010},
      {3'd2, 1'b1, 32'h00000003, 32'h0000000A, 32'hFFFFFFF9, 4'b1000},
      {3'd2, 1'b0, 32'h00000005, 32'h00000005, 32'h00000000, 4'b0110},
      {3'd2, 1'b1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0011},
      {3'd3, 1'b0, 32'h0000000A, 32'h00000003, 32'h00000006, 4'b0010},
      {3'd3, 1'b1, 32'h0000000A, 32'h00000003, 32'h00000007, 4'b0010},
      {3'd4, 1'b1, 32'h0000000A, 32'h0A0B0C0D, 32'h0A0B0C03, 4'b0010},
      {3'd5, 1'b0, 32'h00000004, 32'h00000010, 32'h0000000B, 4'b0010},
      {3'd5, 1'b1, 32'h00000000, 32'h00000000, 32'h00000000, 4'b0110},
      {3'd5, 1'b0, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 4'b1000},
      {3'd6, 1'b1, 32'h00000001, 32'h00000002, 32'h00000003, 4'b0000},
      {3'd7, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0110}
   };

   logic         clk = 1'b0;
   logic         rst_n;
   logic [2:0]   op_i;
   logic [W-1:0] a_i, b_i;
   logic         carry_i, set_flags_i, stat_we_i;
   logic [4:0]   stat_wdata_i;
   logic [W-1:0] result_o;
   logic [3:0]   cand_flags_o;
   logic [4:0]   status_o;

   int  n_checks = 0;
   int  n_fails  = 0;
   logic q_model = 1'b0;

   always #5 clk = ~clk;

   int_alu_flags u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .carry_i(carry_i), .set_flags_i(set_flags_i), .stat_we_i(stat_we_i),
      .stat_wdata_i(stat_wdata_i), .result_o(result_o),
      .cand_flags_o(cand_flags_o), .status_o(status_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'd0, 3'd1: return "R1";
         3'd2, 3'd3: return "R2";
         3'd4, 3'd5: return "R3";
         default:    return "R12";
      endcase
   endfunction

   task automatic drive(input logic [2:0] op, input logic cy, input logic [31:0] a,
                        input logic [31:0] b, input logic sf, input logic we,
                        input logic [4:0] wd);
      @(negedge clk);
      op_i = op; carry_i = cy; a_i = a; b_i = b;
      set_flags_i = sf; stat_we_i = we; stat_wdata_i = wd;
      #1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      op_i = 3'd0; carry_i = 1'b0; a_i = '0; b_i = '0;
      set_flags_i = 1'b1; stat_we_i = 1'b0; stat_wdata_i = 5'h1F;
      repeat (3) @(posedge clk);
      #1;
      check("R10", {27'd0, status_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: result and flags in the same cycle (R11), status after the edge (R7, R8)
      for (int i = 0; i < NV; i++) begin
         logic [2:0]  op;
         logic        cy;
         logic [31:0] a, b, res;
         logic [3:0]  fl;
         {op, cy, a, b, res, fl} = VEC[i];
         drive(op, cy, a, b, 1'b1, 1'b0, 5'd0);
         check(req_of(op), result_o, res);
         check("R4 R5 R6", {28'd0, cand_flags_o}, {28'd0, fl});
         q_model = q_model | fl[0];
         @(posedge clk); #1;
         check("R7 R8", {27'd0, status_o}, {27'd0, fl, q_model});
      end

      // R7 and R11: no set-flags, status holds while result changes
      drive(3'd0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 5'd0);
      check("R11", result_o, 32'h80000000);
      @(posedge clk); #1;
      check("R7", {27'd0, status_o}, {27'd0, 5'b01101});

      // R8: a flag-setting op without overflow leaves Q set
      drive(3'd0, 1'b0, 32'h00000001, 32'h00000002, 1'b1, 1'b0, 5'd0);
      @(posedge clk); #1;
      check("R8", {27'd0, status_o}, {27'd0, 5'b00001});

      // R9: write of zero beats an overflowing set-flags op
      drive(3'd0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b1, 5'd0);
      @(posedge clk); #1;
      check("R9", {27'd0, status_o}, 32'd0);

      // R8: Q stays clear after the write when no overflow follows
      drive(3'd0, 1'b0, 32'h00000001, 32'h00000002, 1'b1, 1'b0, 5'd0);
      @(posedge clk); #1;
      check("R8", {27'd0, status_o}, 32'd0);

      // R9: arbitrary write pattern, with set-flags low
      drive(3'd2, 1'b0, 32'h3, 32'hA, 1'b0, 1'b1, 5'b10101);
      @(posedge clk); #1;
      check("R9", {27'd0, status_o}, {27'd0, 5'b10101});

      finish_run();
   end

endmodule